// File: doc/BRIEF.md
# Sequential Carry-Save Multiplier with Coprocessor Handshake

This block sits beside a CPU core and executes the four multiply instructions of the base integer multiply extension: low-word multiply, signed high word, signed-by-unsigned high word and unsigned high word. The core presents an instruction word, two source operands and a valid strobe. If the word is one of the four multiplies, the block raises a wait indication, works through the operation one multiplier bit per cycle, and then returns the 32-bit result with a one-cycle ready pulse that is paired with a write strobe. Any other instruction passes by untouched.

Partial products are collected in carry-save form, as a sum word and a carry word. Each step adds the shifted multiplicand in short carry chains of a configurable width (four bits by default). Each chain's carry is parked in that chunk's top bit of a carry word, and that word moves up by one bit before the next step. A single full-width addition happens only once, after the last step. The core has to drop the valid strobe before it can issue another multiply, because an operation is launched by the rising edge of a decoded multiply request.

Top module: `copro_mul`

## Requirements
- R1: With opcode insn_i[6:0]=0110011, insn_i[31:25]=0000001 and insn_i[14:12]=000, rd_o returns the low 32 bits of rs1_i*rs2_i (for example 7*6=42 and 12345*6789=83810205).
- R2: With insn_i[14:12]=001 (same opcode and funct7), rd_o returns bits 63:32 of the product of both operands taken as signed; -1 times -1 gives 0.
- R3: With insn_i[14:12]=010, rd_o returns bits 63:32 of signed rs1_i times unsigned rs2_i.
- R4: With insn_i[14:12]=011, rd_o returns bits 63:32 of unsigned rs1_i times unsigned rs2_i.
- R5: An instruction whose opcode is not 0110011, whose funct7 is not 0000001, or whose insn_i[14] is 1 is ignored. For such an instruction wait_o never rises, ready_o and wr_o stay low, and rd_o keeps its value.
- R6: An operation starts only on a rising edge of valid_i together with a multiply decode. A valid_i held high after completion starts nothing, and dropping then reasserting valid_i starts a new operation.
- R7: Counting the first rising clock edge at which valid_i is sampled high as edge 1, ready_o is high after edge 34 for the low-word multiply and after edge 66 for the three high-word variants. wait_o is high from edge 1 until that edge and low while ready_o is high.
- R8: ready_o and wr_o are always equal and last exactly one cycle.
- R9: rd_o changes only in the cycle in which ready_o is high, and otherwise holds the last result.
- R10: After reset, rd_o is 0 and wait_o, ready_o and wr_o are low.
- R11: A rising edge of valid_i while an operation is in progress is ignored. The running operation finishes with its own operands, and no second result follows while valid_i stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe from the core |
| insn_i | input | 32 | Instruction word to decode |
| rs1_i | input | 32 | First operand (multiplicand) |
| rs2_i | input | 32 | Second operand (multiplier) |
| wr_o | output | 1 | Result write strobe, paired with ready_o |
| rd_o | output | 32 | Result word, held until the next completion |
| wait_o | output | 1 | Operation in progress |
| ready_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a fresh rising edge of valid_i that lands while an operation is still running. A well-behaved core never produces it, and the block must neither restart nor corrupt the running accumulation. The bench starts a low-word multiply, lowers valid_i for two cycles in the middle of the run, and then raises it again with different operands and a high-word function code. It then checks that the result is the first product, that the latency is still that of the first operation, and that no further result appears while valid_i stays high. Operand signs at the extremes (all ones, the most negative value) exercise the sign extension that only the high-word variants see.

// File: rtl/copro_mul_pkg.sv
package copro_mul_pkg;

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] F7_MULDIV = 7'b0000001;

  typedef enum logic [1:0] {
    MOP_LO  = 2'd0,
    MOP_HSS = 2'd1,
    MOP_HSU = 2'd2,
    MOP_HUU = 2'd3
  } mop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } st_e;

  typedef struct packed {
    logic hit;
    logic high;
    logic sgn_a;
    logic sgn_b;
  } mdec_t;

endpackage

// File: rtl/mul_decode.sv
module mul_decode
  import copro_mul_pkg::*;
(
  input  logic [31:0] insn_i,
  output mdec_t       dec_o
);

  logic unused_fields;
  assign unused_fields = ^{insn_i[24:15], insn_i[11:7]};

  always_comb begin
    dec_o = '0;
    if (insn_i[6:0] == OPC_REG && insn_i[31:25] == F7_MULDIV && !insn_i[14]) begin
      dec_o.hit = 1'b1;
      unique case (mop_e'(insn_i[13:12]))
        MOP_LO:  dec_o.high = 1'b0;
        MOP_HSS: begin dec_o.high = 1'b1; dec_o.sgn_a = 1'b1; dec_o.sgn_b = 1'b1; end
        MOP_HSU: begin dec_o.high = 1'b1; dec_o.sgn_a = 1'b1; end
        MOP_HUU: dec_o.high = 1'b1;
        default: dec_o.high = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/csa_step.sv
// One accumulation step: chunked carry chains, chunk carry parked in top bit of chunk.
module csa_step #(
  parameter int DW    = 64,
  parameter int CHAIN = 4
) (
  input  logic [DW-1:0] sum_i,
  input  logic [DW-1:0] carry_i,
  input  logic [DW-1:0] addend_i,
  input  logic          add_en_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] carry_o
);

  localparam int NCH = DW / CHAIN;

  logic [DW-1:0] add_g;
  logic [DW-1:0] cout_w;

  assign add_g = add_en_i ? addend_i : '0;

  for (genvar j = 0; j < NCH; j++) begin : g_chunk
    logic [CHAIN:0] t;
    // carry word only holds the chunk LSB, so CHAIN+1 bits cannot overflow
    assign t = {1'b0, sum_i[j*CHAIN +: CHAIN]}
             + {1'b0, carry_i[j*CHAIN +: CHAIN]}
             + {1'b0, add_g[j*CHAIN +: CHAIN]};
    assign sum_o[j*CHAIN +: CHAIN] = t[CHAIN-1:0];
    if (CHAIN > 1) begin : g_pad
      assign cout_w[j*CHAIN +: CHAIN-1] = '0;
    end
    assign cout_w[j*CHAIN+CHAIN-1] = t[CHAIN];
  end

  assign carry_o = cout_w << 1;

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import copro_mul_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] steps_i,
  output logic             load_o,
  output logic             step_o,
  output logic             fin_o,
  output logic             busy_o
);

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = start_i && (st_q == ST_IDLE);
  assign step_o = (st_q == ST_RUN);
  assign fin_o  = (st_q == ST_FIN);
  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RUN;
          cnt_q <= steps_i - CNT_W'(1);
        end
        ST_RUN: begin
          if (cnt_q == '0) st_q <= ST_FIN;
          else             cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/copro_mul.sv
module copro_mul
  import copro_mul_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CHAIN = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic            wr_o,
  output logic [XLEN-1:0] rd_o,
  output logic            wait_o,
  output logic            ready_o
);

  localparam int DW    = 2 * XLEN;
  localparam int CNT_W = $clog2(DW + 1);

  mdec_t         dec;
  logic          arm_q, start;
  logic          load, step, fin, busy;
  logic          high_q, rdy_q;
  logic [DW-1:0] a_q, b_q, sum_q, carry_q;
  logic [DW-1:0] sum_n, carry_n, total;
  logic [XLEN-1:0] res_q;

  mul_decode i_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  assign start = valid_i && dec.hit && !arm_q;

  mul_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .steps_i (dec.high ? CNT_W'(DW) : CNT_W'(XLEN)),
    .load_o  (load),
    .step_o  (step),
    .fin_o   (fin),
    .busy_o  (busy)
  );

  csa_step #(.DW(DW), .CHAIN(CHAIN)) i_csa (
    .sum_i    (sum_q),
    .carry_i  (carry_q),
    .addend_i (a_q),
    .add_en_i (b_q[0]),
    .sum_o    (sum_n),
    .carry_o  (carry_n)
  );

  assign total = sum_q + carry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= valid_i && dec.hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      sum_q   <= '0;
      carry_q <= '0;
      high_q  <= 1'b0;
    end else if (load) begin
      a_q     <= {{XLEN{dec.sgn_a & rs1_i[XLEN-1]}}, rs1_i};
      b_q     <= {{XLEN{dec.sgn_b & rs2_i[XLEN-1]}}, rs2_i};
      sum_q   <= '0;
      carry_q <= '0;
      high_q  <= dec.high;
    end else if (step) begin
      a_q     <= a_q << 1;
      b_q     <= b_q >> 1;
      sum_q   <= sum_n;
      carry_q <= carry_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= fin;
      if (fin) res_q <= high_q ? total[DW-1:XLEN] : total[XLEN-1:0];
    end
  end

  assign rd_o    = res_q;
  assign ready_o = rdy_q;
  assign wr_o    = rdy_q;
  assign wait_o  = busy;

endmodule

// File: rtl/copro_mul_chk.sv
module copro_mul_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [31:0]     insn_i,
  input logic            wr_o,
  input logic [XLEN-1:0] rd_o,
  input logic            wait_o,
  input logic            ready_o
);

  localparam int WC_W = $clog2(2 * XLEN + 3);
  localparam logic [WC_W-1:0] LAT_LO = WC_W'(XLEN + 1);
  localparam logic [WC_W-1:0] LAT_HI = WC_W'(2 * XLEN + 1);

  logic [WC_W-1:0] wcnt_q;
  logic            lat_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q   <= '0;
      lat_hi_q <= 1'b0;
    end else if (wait_o) begin
      wcnt_q   <= wcnt_q + WC_W'(1);
    end else begin
      wcnt_q   <= '0;
      lat_hi_q <= (insn_i[13:12] != 2'b00);
    end
  end

  p_ready_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == wr_o);

  p_ready_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> $stable(rd_o));

  p_wait_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wait_o) |-> $past(valid_i && insn_i[6:0] == 7'b0110011 &&
                            insn_i[31:25] == 7'b0000001 && !insn_i[14]));

  p_wait_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wait_o) |-> ready_o);

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (wcnt_q == (lat_hi_q ? LAT_HI : LAT_LO)));

endmodule

bind copro_mul copro_mul_chk #(.XLEN(XLEN)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .insn_i  (insn_i),
  .wr_o    (wr_o),
  .rd_o    (rd_o),
  .wait_o  (wait_o),
  .ready_o (ready_o)
);

// File: tb/test_copro_mul.sv
module test_copro_mul;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [31:0] rs1_i = '0;
  logic [31:0] rs2_i = '0;
  logic        wr_o, wait_o, ready_o;
  logic [31:0] rd_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  copro_mul i_copro_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .insn_i  (insn_i),
    .rs1_i   (rs1_i),
    .rs2_i   (rs2_i),
    .wr_o    (wr_o),
    .rd_o    (rd_o),
    .wait_o  (wait_o),
    .ready_o (ready_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_insn(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] opc);
    return {f7, 5'd3, 5'd2, f3, 5'd1, opc};
  endfunction

  function automatic logic [31:0] ref_mul(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea, eb, p;
    ea = (f3 == 3'd1 || f3 == 3'd2) ? {{32{a[31]}}, a} : {32'b0, a};
    eb = (f3 == 3'd1) ? {{32{b[31]}}, b} : {32'b0, b};
    p  = ea * eb;
    return (f3 == 3'd0) ? p[31:0] : p[63:32];
  endfunction

  function automatic string req_of(input logic [2:0] f3);
    case (f3)
      3'd0:    return "R1";
      3'd1:    return "R2";
      3'd2:    return "R3";
      default: return "R4";
    endcase
  endfunction

  // counts rising edges until ready_o is seen
  task automatic wait_rdy(inout int cyc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk_i); #1;
      cyc++;
      if (ready_o) begin seen = 1'b1; break; end
    end
  endtask

  task automatic run_op(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b, input bit keep);
    int cyc = 0;
    bit seen, w1;
    @(negedge clk_i);
    valid_i = 1'b1;
    insn_i  = mk_insn(7'b0000001, f3, 7'b0110011);
    rs1_i   = a;
    rs2_i   = b;
    @(posedge clk_i); #1;
    cyc = 1;
    w1 = wait_o;
    wait_rdy(cyc, seen);
    chk("R7", "wait after start", {63'd0, w1}, 64'd1);
    chk("R7", "latency", 64'(cyc), (f3 == 3'd0) ? 64'd34 : 64'd66);
    chk("R7", "wait low at ready", {63'd0, wait_o}, 64'd0);
    chk("R8", "wr with ready", {63'd0, wr_o}, 64'd1);
    chk(req_of(f3), "product", {32'd0, rd_o}, {32'd0, ref_mul(f3, a, b)});
    @(posedge clk_i); #1;
    chk("R8", "ready one cycle", {62'd0, ready_o, wr_o}, 64'd0);
    if (!keep) begin
      @(negedge clk_i);
      valid_i = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R10", "reset outputs", {rd_o, 29'd0, wait_o, ready_o, wr_o}, 64'd0);
  endtask

  task automatic t_basic;
    run_op(3'd0, 32'd7, 32'd6, 1'b0);
    run_op(3'd0, 32'd12345, 32'd6789, 1'b0);
    run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_high;
    run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_op(3'd1, 32'h8000_0000, 32'h8000_0000, 1'b0);
    run_op(3'd1, 32'h1234_5678, 32'hFFFF_FFF9, 1'b0);
    run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_op(3'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_op(3'd3, 32'd12345, 32'd6789, 1'b0);
  endtask

  task automatic t_mixed;
    logic [31:0] lf = 32'hACE1_1234;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a, b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} * 32'd1103515245 + 32'd12345;
      a  = lf;
      lf = lf * 32'd1103515245 + 32'd12345;
      b  = lf ^ 32'h5A5A_0F0F;
      run_op(3'(i % 4), a, b, 1'b0);
    end
  endtask

  task automatic ignore_one(input logic [31:0] w, input string what);
    logic [31:0] prev;
    bit seen_w = 1'b0, seen_r = 1'b0;
    prev = rd_o;
    @(negedge clk_i);
    valid_i = 1'b1;
    insn_i  = w;
    rs1_i   = 32'd99;
    rs2_i   = 32'd77;
    for (int i = 0; i < 80; i++) begin
      @(posedge clk_i); #1;
      if (wait_o) seen_w = 1'b1;
      if (ready_o || wr_o) seen_r = 1'b1;
    end
    chk("R5", {what, " wait"}, {63'd0, seen_w}, 64'd0);
    chk("R5", {what, " ready"}, {63'd0, seen_r}, 64'd0);
    chk("R5", {what, " rd kept"}, {32'd0, rd_o}, {32'd0, prev});
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_ignore;
    ignore_one(mk_insn(7'b0000000, 3'd0, 7'b0110011), "add");
    ignore_one(mk_insn(7'b0000001, 3'd4, 7'b0110011), "div");
    ignore_one(mk_insn(7'b0000001, 3'd0, 7'b0010011), "imm op");
  endtask

  task automatic t_hold_valid;
    bit seen_w = 1'b0, seen_r = 1'b0;
    run_op(3'd0, 32'd1000, 32'd3, 1'b1);
    for (int i = 0; i < 80; i++) begin
      @(posedge clk_i); #1;
      if (wait_o) seen_w = 1'b1;
      if (ready_o) seen_r = 1'b1;
    end
    chk("R6", "held valid no wait", {63'd0, seen_w}, 64'd0);
    chk("R6", "held valid no ready", {63'd0, seen_r}, 64'd0);
    chk("R6", "held valid rd", {32'd0, rd_o}, 64'd3000);
    @(negedge clk_i);
    valid_i = 1'b0;
    run_op(3'd3, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
  endtask

  task automatic t_result_hold;
    logic [31:0] prev;
    bit moved = 1'b0;
    prev = rd_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      rs1_i = 32'(i * 7919);
      rs2_i = ~rs1_i;
      @(posedge clk_i); #1;
      if (rd_o !== prev) moved = 1'b1;
    end
    chk("R9", "rd held while idle", {63'd0, moved}, 64'd0);
  endtask

  task automatic t_busy_edge;
    int cyc = 0;
    bit seen, seen_r = 1'b0;
    @(negedge clk_i);
    valid_i = 1'b1;
    insn_i  = mk_insn(7'b0000001, 3'd0, 7'b0110011);
    rs1_i   = 32'd54321;
    rs2_i   = 32'd111;
    for (int i = 0; i < 5; i++) begin @(posedge clk_i); #1; cyc++; end
    @(negedge clk_i);
    valid_i = 1'b0;
    for (int i = 0; i < 2; i++) begin @(posedge clk_i); #1; cyc++; end
    @(negedge clk_i);
    valid_i = 1'b1;
    insn_i  = mk_insn(7'b0000001, 3'd3, 7'b0110011);
    rs1_i   = 32'hFFFF_0000;
    rs2_i   = 32'h0000_FFFF;
    wait_rdy(cyc, seen);
    chk("R11", "latency of first op", 64'(cyc), 64'd34);
    chk("R11", "first op result", {32'd0, rd_o}, 64'd6029631);
    for (int i = 0; i < 80; i++) begin
      @(posedge clk_i); #1;
      if (ready_o || wait_o) seen_r = 1'b1;
    end
    chk("R11", "no second op", {63'd0, seen_r}, 64'd0);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(64'd4_000_000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_basic();
    t_high();
    t_mixed();
    t_ignore();
    t_hold_valid();
    t_result_hold();
    t_busy_edge();
    finish_run();
  end

endmodule